// File: doc/BRIEF.md
# Chip-Select Region Guard

This block serves a single external chip-select region on an embedded processor bus. A 16-bit control word sets whether the region is live, its size, how many wait states to insert, the data bus width, the write strobe timing for flash parts, and the protection rules. A bus master raises `strobe_i` with an address, a read/write flag, a privilege flag and byte-lane flags. It holds `strobe_i` until it sees `ack_o` or `berr_o`, then drops it. The block drives the active-low chip-select and the lower and upper write strobes.

The region starts at a fixed base address. It is split into an unprotected low part and a protected high part. The protected part can be restricted to supervisor accesses, to reads, or to both. A separate bit makes the whole region read-only. Rule violations raise a one-clock bus error, gated by the global `berr_en_i` input. The exception is a write to a read-only protected block, which always raises the error. A violation that is not reported still completes, but its write strobes are held off.

Top module: `cs_guard`

## Requirements
- R1: After reset the control word reads 0x0000, `cs_no`, `lwe_no` and `uwe_no` are high, and `ack_o` and `berr_o` are low.
- R2: A write on `cfg_we_i` stores `cfg_wdata_i`, and bits 10:9 always read back as 0. Field positions: bit 15 region read-only, bit 14 protected-block supervisor-only, bit 13 protected-block read-only, bits 12:11 unprotected size code, bit 8 flash timing, bit 7 width (0 = 8-bit, 1 = 16-bit), bits 6:4 region size code, bits 3:1 wait states, bit 0 enable.
- R3: A cycle starts only when bit 0 is set and the address lies in [BASE_ADDR, BASE_ADDR + 32K·2^size code). Any other strobe is ignored: no chip-select, no acknowledge.
- R4: Chip-select goes low on the first clock after the strobe is sampled. `ack_o` rises after the programmed number of extra clocks, so for a read it appears in active cycle ws+1. Chip-select stays low through the acknowledge cycle.
- R5: With bit 8 set, a write drives its write strobes one clock after chip-select, and the acknowledge moves one clock later. Reads are unaffected. With bit 8 clear, the write strobes fall together with chip-select.
- R6: In 8-bit mode only `lwe_no` is driven, for any write with either lane flag set. In 16-bit mode `lwe_no` follows `lb_i` and `uwe_no` follows `ub_i`.
- R7: With bit 15 set and `berr_en_i` high, any write to the region raises `berr_o`. Reads still complete.
- R8: With bit 14 set and `berr_en_i` high, a user access (`super_i` low) to the protected block raises `berr_o`. Supervisor accesses complete.
- R9: With bit 13 set, a write to the protected block raises `berr_o` whatever `berr_en_i` is.
- R10: An offset below 32K·2^(bits 12:11) is unprotected. An offset at or above it is protected.
- R11: A region read-only or supervisor-only violation with `berr_en_i` low completes with `ack_o` and chip-select, but both write strobes stay high.
- R12: `berr_o` is a one-clock pulse in the first clock after the strobe is sampled. During it, chip-select, both write strobes and `ack_o` are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write enable |
| cfg_wdata_i | input | 16 | Control word write data |
| cfg_rdata_o | output | 16 | Control word readback |
| berr_en_i | input | 1 | Global bus-error reporting enable |
| strobe_i | input | 1 | Bus cycle request, held until ack or error |
| addr_i | input | ADDR_W | Byte address |
| wr_i | input | 1 | 1 = write, 0 = read |
| super_i | input | 1 | 1 = supervisor, 0 = user |
| lb_i | input | 1 | Lower byte lane selected |
| ub_i | input | 1 | Upper byte lane selected |
| cs_no | output | 1 | Chip-select, active low |
| lwe_no | output | 1 | Lower write strobe, active low |
| uwe_no | output | 1 | Upper write strobe, active low |
| ack_o | output | 1 | Cycle complete |
| berr_o | output | 1 | Bus error pulse |

## Verification
The bound checker watches several properties on every clock:
- the bus error is a single pulse with all strobes quiet;
- the reserved bits read as zero;
- a flash write holds its strobes off on the clock chip-select falls;
- the upper strobe stays silent in 8-bit mode;
- an acknowledge never comes before the programmed wait count;
- a disabled region never selects.

Only the bench scenarios can show the address decisions themselves. These are the region bounds, the split at the unprotected-size boundary, and which privilege and direction combinations error or complete. The scenarios also show that an unreported violation completes with its write strobes suppressed.

// File: rtl/cs_guard_pkg.sv
package cs_guard_pkg;
  localparam int CFG_W = 16;
  localparam int WS_W  = 3;

  typedef struct packed {
    logic            ro;
    logic            sop;
    logic            rop;
    logic [1:0]      upsiz;
    logic [1:0]      rsv;
    logic            flash;
    logic            wide;
    logic [2:0]      rsiz;
    logic [WS_W-1:0] ws;
    logic            en;
  } cs_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_DONE} cyc_st_e;
endpackage

// File: rtl/cs_cfg_reg.sv
module cs_cfg_reg
  import cs_guard_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cs_cfg_t          cfg_o
);
  cs_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d     = cs_cfg_t'(wdata_i);
    cfg_d.rsv = '0;  // reserved bits never stored
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/cs_region_chk.sv
module cs_region_chk #(
  parameter int                ADDR_W       = 24,
  parameter int                MIN_BLK_LOG2 = 15,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 'h400000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        rsiz_i,
  input  logic [1:0]        upsiz_i,
  input  logic              ro_i,
  input  logic              sop_i,
  input  logic              rop_i,
  input  logic              wr_i,
  input  logic              super_i,
  input  logic              berr_en_i,
  output logic              hit_o,
  output logic              err_o,
  output logic              mute_o
);
  localparam logic [ADDR_W-1:0] MIN_BLK = ADDR_W'(1) << MIN_BLK_LOG2;

  logic [ADDR_W-1:0] mask, up_size, offset;
  logic              prot, ro_v, sop_v, rop_v;

  always_comb begin
    mask    = (MIN_BLK << rsiz_i) - ADDR_W'(1);
    up_size = MIN_BLK << upsiz_i;
    offset  = addr_i & mask;
    hit_o   = (addr_i & ~mask) == (BASE_ADDR & ~mask);
    prot    = offset >= up_size;
    ro_v    = ro_i & wr_i;
    sop_v   = prot & sop_i & ~super_i;
    rop_v   = prot & rop_i & wr_i;
    // protected-block read-only error is not gated by the global enable
    err_o   = rop_v | (berr_en_i & (ro_v | sop_v));
    mute_o  = ro_v | sop_v;
  end
endmodule

// File: rtl/cs_cycle_fsm.sv
module cs_cycle_fsm
  import cs_guard_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            strobe_i,
  input  logic            err_i,
  input  logic            mute_i,
  input  logic            wr_i,
  input  logic            lb_i,
  input  logic            ub_i,
  input  logic            wide_i,
  input  logic            flash_i,
  input  logic [WS_W-1:0] ws_i,
  output logic            cs_no,
  output logic            lwe_no,
  output logic            uwe_no,
  output logic            ack_o,
  output logic            berr_o
);
  cyc_st_e         st_q;
  logic [WS_W-1:0] cnt_q;
  logic            weon_q, wr_q, lo_q, hi_q, berr_q;
  logic            act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      weon_q <= 1'b0;
      wr_q   <= 1'b0;
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      berr_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (err_i) begin
            berr_q <= 1'b1;
            st_q   <= ST_DONE;
          end else begin
            st_q   <= ST_ACT;
            cnt_q  <= ws_i;
            weon_q <= ~(flash_i & wr_i);  // flash writes lag chip-select
            wr_q   <= wr_i & ~mute_i;
            lo_q   <= wide_i ? lb_i : (lb_i | ub_i);
            hi_q   <= wide_i & ub_i;
          end
        end
        ST_ACT: begin
          if (!weon_q)           weon_q <= 1'b1;
          else if (cnt_q != '0)  cnt_q  <= cnt_q - 1'b1;
          else                   st_q   <= ST_DONE;
        end
        ST_DONE: if (!strobe_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign act    = (st_q == ST_ACT);
  assign cs_no  = ~act;
  assign lwe_no = ~(act & weon_q & wr_q & lo_q);
  assign uwe_no = ~(act & weon_q & wr_q & hi_q);
  assign ack_o  = act & weon_q & (cnt_q == '0);
  assign berr_o = berr_q;
endmodule

// File: rtl/cs_guard.sv
module cs_guard
  import cs_guard_pkg::*;
#(
  parameter int                ADDR_W       = 24,
  parameter int                MIN_BLK_LOG2 = 15,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 'h400000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  input  logic              berr_en_i,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              super_i,
  input  logic              lb_i,
  input  logic              ub_i,
  output logic              cs_no,
  output logic              lwe_no,
  output logic              uwe_no,
  output logic              ack_o,
  output logic              berr_o
);
  cs_cfg_t cfg;
  logic    hit, err, mute, start;

  cs_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  cs_region_chk #(
    .ADDR_W       (ADDR_W),
    .MIN_BLK_LOG2 (MIN_BLK_LOG2),
    .BASE_ADDR    (BASE_ADDR)
  ) u_region (
    .addr_i    (addr_i),
    .rsiz_i    (cfg.rsiz),
    .upsiz_i   (cfg.upsiz),
    .ro_i      (cfg.ro),
    .sop_i     (cfg.sop),
    .rop_i     (cfg.rop),
    .wr_i      (wr_i),
    .super_i   (super_i),
    .berr_en_i (berr_en_i),
    .hit_o     (hit),
    .err_o     (err),
    .mute_o    (mute)
  );

  assign start = strobe_i & hit & cfg.en;

  cs_cycle_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .strobe_i (strobe_i),
    .err_i    (err),
    .mute_i   (mute),
    .wr_i     (wr_i),
    .lb_i     (lb_i),
    .ub_i     (ub_i),
    .wide_i   (cfg.wide),
    .flash_i  (cfg.flash),
    .ws_i     (cfg.ws),
    .cs_no    (cs_no),
    .lwe_no   (lwe_no),
    .uwe_no   (uwe_no),
    .ack_o    (ack_o),
    .berr_o   (berr_o)
  );

  assign cfg_rdata_o = cfg;
endmodule

// File: rtl/cs_guard_chk.sv
module cs_guard_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cfg_rdata_o,
  input logic        cs_no,
  input logic        lwe_no,
  input logic        uwe_no,
  input logic        ack_o,
  input logic        berr_o
);
  logic [3:0] act_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              act_cnt <= '0;
    else if (cs_no)           act_cnt <= '0;
    else if (act_cnt != 4'hF) act_cnt <= act_cnt + 4'd1;
  end

  // R12
  berr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |=> !berr_o);
  // R12
  berr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> (cs_no && lwe_no && uwe_no && !ack_o));
  // R2
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[10:9] == 2'b00);
  // R5
  flash_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_no) && cfg_rdata_o[8]) |-> (lwe_no && uwe_no));
  // R6
  narrow_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_rdata_o[7] && cs_no) |=> uwe_no);
  // R4
  ack_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !cs_no);
  // R4
  min_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (act_cnt >= {1'b0, cfg_rdata_o[3:1]}));
  // R3
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_rdata_o[0] && cs_no) |=> cs_no);
endmodule

bind cs_guard cs_guard_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_rdata_o (cfg_rdata_o),
  .cs_no       (cs_no),
  .lwe_no      (lwe_no),
  .uwe_no      (uwe_no),
  .ack_o       (ack_o),
  .berr_o      (berr_o)
);

// File: tb/cs_guard_tb_top.sv
`timescale 1ns/1ps
module cs_guard_tb_top;
  localparam logic [23:0] BASE = 24'h400000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        berr_en = 1'b0, strobe = 1'b0, wr = 1'b0, sup = 1'b0, lb = 1'b0, ub = 1'b0;
  logic [23:0] addr = '0;
  logic        cs_n, lwe_n, uwe_n, ack, berr;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  cs_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .berr_en_i(berr_en), .strobe_i(strobe), .addr_i(addr),
    .wr_i(wr), .super_i(sup), .lb_i(lb), .ub_i(ub), .cs_no(cs_n), .lwe_no(lwe_n),
    .uwe_no(uwe_n), .ack_o(ack), .berr_o(berr)
  );

  // behavioural reference model
  int          m_st, m_cnt;
  bit          m_weon, m_wr, m_lo, m_hi, m_berr;
  logic [15:0] m_cfg;

  function automatic bit in_region(logic [23:0] a, logic [15:0] c);
    longint sz = longint'(32768) << c[6:4];
    return (longint'(a) / sz) == (longint'(BASE) / sz);
  endfunction

  function automatic bit is_prot(logic [23:0] a, logic [15:0] c);
    longint sz = longint'(32768) << c[6:4];
    return (longint'(a) % sz) >= (longint'(32768) << c[12:11]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_weon = 0; m_wr = 0; m_lo = 0; m_hi = 0; m_berr = 0; m_cfg = '0;
    end else begin
      m_berr = 0;
      case (m_st)
        0: if (strobe && m_cfg[0] && in_region(addr, m_cfg)) begin
          bit p, rov, sov, rpv;
          p   = is_prot(addr, m_cfg);
          rov = m_cfg[15] && wr;
          sov = p && m_cfg[14] && !sup;
          rpv = p && m_cfg[13] && wr;
          if (rpv || (berr_en && (rov || sov))) begin
            m_berr = 1; m_st = 2;
          end else begin
            m_st = 1; m_cnt = int'(m_cfg[3:1]); m_weon = !(m_cfg[8] && wr);
            m_wr = wr && !(rov || sov);
            m_lo = m_cfg[7] ? lb : (lb || ub);
            m_hi = m_cfg[7] && ub;
          end
        end
        1: if (!m_weon) m_weon = 1; else if (m_cnt > 0) m_cnt--; else m_st = 2;
        default: if (!strobe) m_st = 0;
      endcase
      if (cfg_we) m_cfg = cfg_wdata & 16'hF9FF;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [4:0] e, a;
      e = {m_st != 1, !(m_st == 1 && m_weon && m_wr && m_lo), !(m_st == 1 && m_weon && m_wr && m_hi),
           m_st == 1 && m_weon && m_cnt == 0, m_berr};
      a = {cs_n, lwe_n, uwe_n, ack, berr};
      total++;
      if (a !== e || cfg_rdata !== m_cfg) begin
        bad++;
        $display("FAIL %s cycle act=%b/%h exp=%b/%h", cur_req, a, cfg_rdata, e, m_cfg);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wcfg(logic [15:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
    check(cfg_rdata == (v & 16'hF9FF), "R2", int'(cfg_rdata), int'(v & 16'hF9FF));
  endtask

  // k: clock index of ack/berr (0 = none); csk/wek: first index of select / any write strobe
  task automatic bus(logic [23:0] a, bit w, bit s, bit l, bit u,
                     output int k, output int nberr, output int csk, output int wek,
                     output bit lw, output bit uw);
    k = 0; nberr = 0; csk = 0; wek = 0; lw = 0; uw = 0;
    @(negedge clk); addr = a; wr = w; sup = s; lb = l; ub = u; strobe = 1;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      if (!cs_n && csk == 0) csk = i;
      if ((!lwe_n || !uwe_n) && wek == 0) wek = i;
      if (!lwe_n) lw = 1;
      if (!uwe_n) uw = 1;
      if (berr) nberr++;
      if ((ack || berr) && k == 0) k = i;
      if (k != 0 && i >= k + 2) break;
    end
    strobe = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #80000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k, nb, ck, wk;
    bit lw, uw;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check(cfg_rdata == 16'h0000, "R1", int'(cfg_rdata), 0);
    check({cs_n, lwe_n, uwe_n, ack, berr} == 5'b11100, "R1", int'({cs_n, lwe_n, uwe_n, ack, berr}), 28);
    rst_n = 1;
    @(negedge clk);
    check(cfg_rdata == 16'h0000, "R1", int'(cfg_rdata), 0);

    // R3: disabled region ignores strobe
    cur_req = "R3";
    bus(BASE + 24'h10, 0, 1, 1, 1, k, nb, ck, wk, lw, uw);
    check(k == 0 && ck == 0, "R3", ck, 0);

    // R2: reserved bits
    cur_req = "R2";
    wcfg(16'hFFFF);
    check(cfg_rdata[10:9] == 2'b00, "R2", int'(cfg_rdata[10:9]), 0);

    // R4: 16-bit, ws=2, 32K region
    cur_req = "R4";
    wcfg(16'h0085);
    bus(BASE + 24'h100, 0, 1, 1, 1, k, nb, ck, wk, lw, uw);
    check(k == 3 && ck == 1, "R4", k, 3);
    bus(BASE + 24'h200, 1, 1, 1, 0, k, nb, ck, wk, lw, uw);
    check(wk == 1 && k == 3, "R6", wk, 1);
    check(lw && !uw, "R6", int'({lw, uw}), 2);
    bus(BASE + 24'h202, 1, 1, 0, 1, k, nb, ck, wk, lw, uw);
    check(!lw && uw, "R6", int'({lw, uw}), 1);
    cur_req = "R3";
    bus(BASE + 24'h8000, 0, 1, 1, 1, k, nb, ck, wk, lw, uw);
    check(k == 0 && ck == 0, "R3", ck, 0);
    bus(BASE - 24'h1, 0, 1, 1, 1, k, nb, ck, wk, lw, uw);
    check(k == 0 && ck == 0, "R3", ck, 0);

    // R6: narrow mode, upper lane only still drives lower strobe
    cur_req = "R6";
    wcfg(16'h0001);
    bus(BASE + 24'h4, 1, 1, 0, 1, k, nb, ck, wk, lw, uw);
    check(lw && !uw && k == 1, "R6", int'({lw, uw}), 2);

    // R5: flash timing
    cur_req = "R5";
    wcfg(16'h0103);
    bus(BASE + 24'h8, 1, 1, 1, 0, k, nb, ck, wk, lw, uw);
    check(ck == 1 && wk == 2, "R5", wk, 2);
    check(k == 3, "R5", k, 3);
    bus(BASE + 24'h8, 0, 1, 1, 0, k, nb, ck, wk, lw, uw);
    check(k == 2, "R5", k, 2);

    // R7 / R11: whole-region read-only
    cur_req = "R7";
    wcfg(16'h8001);
    berr_en = 1;
    bus(BASE + 24'h10, 1, 1, 1, 0, k, nb, ck, wk, lw, uw);
    check(k == 1 && nb == 1 && ck == 0, "R7", nb, 1);
    bus(BASE + 24'h10, 0, 1, 1, 0, k, nb, ck, wk, lw, uw);
    check(k == 1 && nb == 0 && ck == 1, "R7", nb, 0);
    cur_req = "R11";
    berr_en = 0;
    bus(BASE + 24'h10, 1, 1, 1, 0, k, nb, ck, wk, lw, uw);
    check(k == 1 && nb == 0 && ck == 1 && wk == 0, "R11", wk, 0);

    // R8 / R10: supervisor-only protected block, 64K region, 32K unprotected
    cur_req = "R8";
    wcfg(16'h4011);
    berr_en = 1;
    bus(BASE + 24'h9000, 0, 0, 1, 0, k, nb, ck, wk, lw, uw);
    check(k == 1 && nb == 1 && ck == 0, "R8", nb, 1);
    bus(BASE + 24'h9000, 0, 1, 1, 0, k, nb, ck, wk, lw, uw);
    check(k == 1 && nb == 0 && ck == 1, "R8", nb, 0);
    cur_req = "R10";
    bus(BASE + 24'h7FFF, 0, 0, 1, 0, k, nb, ck, wk, lw, uw);
    check(k == 1 && nb == 0, "R10", nb, 0);
    bus(BASE + 24'h8000, 0, 0, 1, 0, k, nb, ck, wk, lw, uw);
    check(nb == 1, "R10", nb, 1);
    cur_req = "R11";
    berr_en = 0;
    bus(BASE + 24'h9000, 1, 0, 1, 0, k, nb, ck, wk, lw, uw);
    check(k == 1 && nb == 0 && wk == 0, "R11", wk, 0);

    // R9 / R10: protected read-only, 128K region, 64K unprotected
    cur_req = "R9";
    wcfg(16'h2821);
    bus(BASE + 24'hFFFF, 1, 1, 1, 0, k, nb, ck, wk, lw, uw);
    check(k == 1 && nb == 0 && lw, "R10", nb, 0);
    bus(BASE + 24'h10000, 1, 1, 1, 0, k, nb, ck, wk, lw, uw);
    check(k == 1 && nb == 1 && ck == 0 && wk == 0, "R9", nb, 1);
    bus(BASE + 24'h10000, 0, 1, 1, 0, k, nb, ck, wk, lw, uw);
    check(k == 1 && nb == 0, "R9", nb, 0);

    // R12: held strobe after error produces exactly one pulse
    cur_req = "R12";
    berr_en = 1;
    bus(BASE + 24'h1FFFE, 1, 1, 1, 0, k, nb, ck, wk, lw, uw);
    check(nb == 1 && ck == 0, "R12", nb, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule